// File: doc/BRIEF.md
# Serial Transmit Buffer and Line Controller

This block is the transmit half of a serial port that can send either framed asynchronous characters or raw synchronous characters. The host places a character in a one-deep holding buffer with a write strobe. The character moves into a frame shift register only when the character already on the line has finished. Each such move sets a sticky buffer-empty flag. If a character ends and nothing new is waiting, a sticky underrun flag is set. In that case the line either rests at mark (asynchronous) or keeps repeating a programmed sync character (synchronous).

While the transmitter is off, the line is forced to a host-selected level: high, low or released. When the enable is raised, the line is driven high for one bit time and then the first character goes out. When the enable is dropped, a character already on the line is finished, a character still in the buffer is kept for later, and no flag changes because of the disable. An optional turnaround pulse tells the receiver side to switch on each time the transmitter comes to rest. Bit timing comes from an external one-cycle-per-bit strobe.

Top module: `usart_tx_ctrl`

## Requirements
- R1: A write strobe stores wr_data in the holding buffer and overwrites any unsent character there. The buffer moves into the shift register only on a bit strobe that ends the lead-in bit, that occurs while resting, or that ends the last bit of the current character. The character that moves is the one held before a write in that same cycle.
- R2: buf_empty is 1 after reset. It is set on every move from the buffer to the shift register. It is cleared by a write or by clr_empty. A write beats the set, and the set beats clr_empty.
- R3: An asynchronous character is sent as 10 bit times: a 0 start bit, the 8 data bits least significant first, then a 1 stop bit. When the buffer is full at the end of the stop bit, the next start bit follows at once.
- R4: In asynchronous format, an enabled transmitter with no character waiting drives 1 (mark) on every bit time.
- R5: In synchronous format, a character is 8 bit times of data, least significant first, with no framing bits. With no character waiting, sync_char is loaded and sent repeatedly.
- R6: While the transmitter is off, tx_drive and tx_line follow pre_level: 00 gives tx_drive=0 (line released), 01 gives a driven 0, and 10 or 11 give a driven 1. After reset the line is released. tx_line and tx_drive are registered and lag the internal state by one clock.
- R7: Enable takes effect on the first bit strobe that sees tx_en=1. The line is then driven 1 for exactly one bit time before any character or sync pattern starts.
- R8: underrun is a sticky flag. It is set when a character finishes while tx_en=1 and the buffer is empty, and it is cleared by clr_underrun. The set beats the clear. It is never set at the end of the lead-in bit.
- R9: If tx_en falls during a character, that character is sent to its last bit. The buffered character stays in the buffer, buf_empty does not change, and underrun is not set. The kept character is sent after the next enable.
- R10: If tx_en is 0 at a bit strobe while the transmitter is in lead-in or resting at mark, it stops on that strobe and the line returns to the pre_level state.
- R11: When auto_turn=1, rx_turn_on pulses high for one clock, one clock after the transmitter enters the off state. It stays 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-clock strobe per bit time |
| tx_en | input | 1 | Transmitter enable |
| sync_mode | input | 1 | 1 = synchronous format, 0 = asynchronous |
| pre_level | input | 2 | Line state while off: 00 released, 01 low, 1x high |
| auto_turn | input | 1 | Request a receiver turn-on pulse when the transmitter stops |
| sync_char | input | DATA_W | Pattern repeated in synchronous idle |
| wr_stb | input | 1 | Holding buffer write strobe |
| wr_data | input | DATA_W | Character to send |
| clr_empty | input | 1 | Clear buf_empty |
| clr_underrun | input | 1 | Clear underrun |
| tx_line | output | 1 | Serial output value |
| tx_drive | output | 1 | Output enable for tx_line (0 = released) |
| buf_empty | output | 1 | Sticky buffer-empty flag |
| underrun | output | 1 | Sticky underrun flag |
| rx_turn_on | output | 1 | One-clock receiver enable pulse |

## Verification
The hardest case to reach is a disable that lands while a character is mid-frame and a second character is already buffered. The kept character must survive the stop, must leave no flag change, and must then go out after a later enable. A directed sequence writes one character and waits a few bit times. It then writes a second character and drops the enable, runs past the frame end, and enables again. Random traffic afterwards toggles the enable, the formats and the clears at rates that revisit this case and the back-to-back case many times. Every output is compared on every clock against a bench model that works at frame-bit granularity.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic [1:0] {
    TX_OFF   = 2'd0,
    TX_LEAD  = 2'd1,
    TX_IDLE  = 2'd2,
    TX_SHIFT = 2'd3
  } tx_state_e;

  localparam logic [1:0] LVL_FLOAT = 2'b00;
  localparam logic [1:0] LVL_LOW   = 2'b01;
endpackage

// File: rtl/utx_buffer.sv
module utx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_buf,
  input  logic              clr_empty,
  input  logic              clr_under,
  input  logic              under_set,
  output logic              buf_full,
  output logic [DATA_W-1:0] buf_data,
  output logic              empty_flag,
  output logic              under_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_full   <= 1'b0;
      buf_data   <= '0;
      empty_flag <= 1'b1;
      under_flag <= 1'b0;
    end else begin
      if (wr_stb) begin
        buf_full <= 1'b1;
        buf_data <= wr_data;
      end else if (load_buf) begin
        buf_full <= 1'b0;
      end

      if (wr_stb)         empty_flag <= 1'b0;
      else if (load_buf)  empty_flag <= 1'b1;
      else if (clr_empty) empty_flag <= 1'b0;

      if (under_set)      under_flag <= 1'b1;
      else if (clr_under) under_flag <= 1'b0;
    end
  end

  // R1
  load_from_empty_chk: assert property (@(posedge clk) disable iff (rst)
    load_buf |-> buf_full);

  // R8
  underrun_with_data_chk: assert property (@(posedge clk) disable iff (rst)
    under_set |-> !buf_full);
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              sync_fmt,
  input  logic [DATA_W-1:0] load_data,
  input  logic              step,
  output logic              line_bit,
  output logic              done
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CW      = $clog2(FRAME_W);
  localparam logic [CW-1:0] ASYNC_LAST = CW'(FRAME_W - 1);
  localparam logic [CW-1:0] SYNC_LAST  = CW'(DATA_W - 1);

  logic [FRAME_W-1:0] sreg_q;
  logic [CW-1:0]      left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '1;
      left_q <= '0;
    end else if (load) begin
      if (sync_fmt) begin
        sreg_q <= {2'b11, load_data};
        left_q <= SYNC_LAST;
      end else begin
        sreg_q <= {1'b1, load_data, 1'b0};
        left_q <= ASYNC_LAST;
      end
    end else if (step) begin
      sreg_q <= {1'b1, sreg_q[FRAME_W-1:1]};
      left_q <= left_q - 1'b1;
    end
  end

  assign line_bit = sreg_q[0];
  assign done     = (left_q == '0);

  // R3
  reload_mid_char_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> left_q == '0);

  // R5
  step_past_end_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> left_q != '0);
endmodule

// File: rtl/utx_seq.sv
module utx_seq import utx_pkg::*; (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      tx_en,
  input  logic      sync_mode,
  input  logic      buf_full,
  input  logic      done,
  output tx_state_e state,
  output logic      load_buf,
  output logic      load_sync,
  output logic      step,
  output logic      under_set,
  output logic      go_off
);
  tx_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    load_buf  = 1'b0;
    load_sync = 1'b0;
    step      = 1'b0;
    under_set = 1'b0;
    go_off    = 1'b0;
    if (tick) begin
      unique case (state_q)
        TX_OFF: begin
          if (tx_en) state_d = TX_LEAD;
        end
        TX_LEAD, TX_IDLE: begin
          if (!tx_en) begin
            state_d = TX_OFF;
            go_off  = 1'b1;
          end else if (buf_full) begin
            load_buf = 1'b1;
            state_d  = TX_SHIFT;
          end else if (sync_mode) begin
            load_sync = 1'b1;
            state_d   = TX_SHIFT;
          end else begin
            state_d = TX_IDLE;
          end
        end
        TX_SHIFT: begin
          if (!done) begin
            step = 1'b1;
          end else if (!tx_en) begin
            state_d = TX_OFF;
            go_off  = 1'b1;
          end else if (buf_full) begin
            load_buf = 1'b1;
          end else begin
            under_set = 1'b1;
            if (sync_mode) load_sync = 1'b1;
            else           state_d   = TX_IDLE;
          end
        end
        default: state_d = TX_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= TX_OFF;
    else     state_q <= state_d;
  end

  assign state = state_q;

  // R10
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == TX_OFF && !tick) |=> state_q == TX_OFF);

  // R7
  lead_once_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == TX_LEAD && tick) |=> state_q != TX_LEAD);

  // R1
  single_load_chk: assert property (@(posedge clk) disable iff (rst)
    !(load_buf && load_sync));
endmodule

// File: rtl/usart_tx_ctrl.sv
module usart_tx_ctrl import utx_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              sync_mode,
  input  logic [1:0]        pre_level,
  input  logic              auto_turn,
  input  logic [DATA_W-1:0] sync_char,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_empty,
  input  logic              clr_underrun,
  output logic              tx_line,
  output logic              tx_drive,
  output logic              buf_empty,
  output logic              underrun,
  output logic              rx_turn_on
);
  tx_state_e         state;
  logic              load_buf, load_sync, step, under_set, go_off;
  logic              buf_full, done, line_bit;
  logic [DATA_W-1:0] buf_data, load_data;
  logic              line_q, drive_q, turn_q;

  utx_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (bit_tick),
    .tx_en     (tx_en),
    .sync_mode (sync_mode),
    .buf_full  (buf_full),
    .done      (done),
    .state     (state),
    .load_buf  (load_buf),
    .load_sync (load_sync),
    .step      (step),
    .under_set (under_set),
    .go_off    (go_off)
  );

  utx_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .load_buf   (load_buf),
    .clr_empty  (clr_empty),
    .clr_under  (clr_underrun),
    .under_set  (under_set),
    .buf_full   (buf_full),
    .buf_data   (buf_data),
    .empty_flag (buf_empty),
    .under_flag (underrun)
  );

  assign load_data = load_sync ? sync_char : buf_data;

  utx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load_buf | load_sync),
    .sync_fmt  (sync_mode),
    .load_data (load_data),
    .step      (step),
    .line_bit  (line_bit),
    .done      (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= 1'b1;
      drive_q <= 1'b0;
      turn_q  <= 1'b0;
    end else begin
      unique case (state)
        TX_OFF: begin
          drive_q <= (pre_level != LVL_FLOAT);
          line_q  <= (pre_level != LVL_LOW);
        end
        TX_SHIFT: begin
          drive_q <= 1'b1;
          line_q  <= line_bit;
        end
        default: begin
          drive_q <= 1'b1;
          line_q  <= 1'b1;
        end
      endcase
      turn_q <= auto_turn & go_off;
    end
  end

  assign tx_line    = line_q;
  assign tx_drive   = drive_q;
  assign rx_turn_on = turn_q;

  // R11
  turn_in_off_chk: assert property (@(posedge clk) disable iff (rst)
    turn_q |-> state == TX_OFF);

  // R6
  released_only_off_chk: assert property (@(posedge clk) disable iff (rst)
    (state != TX_OFF) |=> drive_q);
endmodule

// File: tb/usart_tx_ctrl_tb_top.sv
`timescale 1ns/1ps
module usart_tx_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       i_tick = 0, i_en = 0, i_sync = 0, i_auto = 0;
  logic [1:0] i_lvl = 2'b00;
  logic [7:0] i_sc = 8'h00, i_d = 8'h00;
  logic       i_wr = 0, i_clre = 0, i_clru = 0;
  logic       tx_line, tx_drive, buf_empty, underrun, rx_turn_on;

  int n_chk = 0, n_bad = 0, ph = 0;
  bit rnd = 0;

  // bench model
  int         m_st = 0;
  logic       m_full = 0, m_fmt = 0, m_empty = 1, m_under = 0;
  logic [7:0] m_buf = 0, m_data = 8'hFF;
  int         m_idx = 0;
  logic       m_line = 1, m_oe = 0, m_turn = 0;
  string      m_tag = "R6";

  always #10 clk = ~clk;

  usart_tx_ctrl #(.DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .bit_tick(i_tick), .tx_en(i_en), .sync_mode(i_sync),
    .pre_level(i_lvl), .auto_turn(i_auto), .sync_char(i_sc), .wr_stb(i_wr),
    .wr_data(i_d), .clr_empty(i_clre), .clr_underrun(i_clru),
    .tx_line(tx_line), .tx_drive(tx_drive), .buf_empty(buf_empty),
    .underrun(underrun), .rx_turn_on(rx_turn_on)
  );

  function automatic logic frame_bit(logic sync, logic [7:0] d, int idx);
    if (sync) return d[idx];
    if (idx == 0) return 1'b0;
    if (idx == 9) return 1'b1;
    return d[idx-1];
  endfunction

  function automatic int last_idx(logic sync);
    return sync ? 7 : 9;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check({m_tag, " tx_drive"}, tx_drive, m_oe);
    if (m_oe) check({m_tag, " tx_line"}, tx_line, m_line);
    check("R1/R2/R9 buf_empty", buf_empty, m_empty);
    check("R8/R9 underrun", underrun, m_under);
    check("R11 rx_turn_on", rx_turn_on, m_turn);
  endtask

  task automatic model_step();
    logic ld_buf = 0, ld_sync = 0, adv = 0, uset = 0, off = 0;
    int   nst = m_st;
    // registered line from present state
    case (m_st)
      0: begin m_oe = (i_lvl != 2'b00); m_line = (i_lvl != 2'b01); m_tag = "R6"; end
      1: begin m_oe = 1; m_line = 1; m_tag = "R7"; end
      2: begin m_oe = 1; m_line = 1; m_tag = "R4"; end
      default: begin
        m_oe = 1; m_line = frame_bit(m_fmt, m_data, m_idx);
        m_tag = m_fmt ? "R5" : "R3";
      end
    endcase
    if (i_tick) begin
      if (m_st == 0) begin
        if (i_en) nst = 1;
      end else if (m_st == 3 && m_idx != last_idx(m_fmt)) begin
        adv = 1;
      end else if (!i_en) begin
        nst = 0; off = 1;
      end else if (m_full) begin
        ld_buf = 1; nst = 3;
      end else begin
        if (m_st == 3) uset = 1;
        if (i_sync) begin ld_sync = 1; nst = 3; end
        else nst = 2;
      end
    end
    if (ld_buf || ld_sync) begin
      m_data = ld_buf ? m_buf : i_sc; m_fmt = i_sync; m_idx = 0;
    end else if (adv) m_idx++;
    if (i_wr) m_empty = 0;
    else if (ld_buf) m_empty = 1;
    else if (i_clre) m_empty = 0;
    if (i_wr) begin m_full = 1; m_buf = i_d; end
    else if (ld_buf) m_full = 0;
    if (uset) m_under = 1;
    else if (i_clru) m_under = 0;
    m_turn = i_auto & off;
    m_st = nst;
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) begin
      if (rnd) begin
        i_wr   = ($urandom % 12) == 0;
        i_d    = 8'($urandom);
        i_clre = ($urandom % 20) == 0;
        i_clru = ($urandom % 20) == 0;
        if (($urandom % 150) == 0) begin
          i_en   = ~i_en;
          i_lvl  = 2'($urandom);
          i_auto = 1'($urandom);
        end
        if (m_st == 0 && !i_en && ($urandom % 50) == 0) begin
          i_sync = ~i_sync;
          i_sc   = 8'($urandom);
        end
      end
      i_tick = (ph == 3);
      ph = (ph + 1) % 4;
      model_step();
      @(posedge clk); #1;
      i_wr = 0; i_clre = 0; i_clru = 0;
      @(negedge clk);
      compare();
    end
  endtask

  task automatic write(logic [7:0] d);
    i_d = d; i_wr = 1; cyc(1);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // reset state: R2 empty set, R6 released
    compare();
    rst = 0;
    // R6 pre-enable levels
    i_lvl = 2'b10; cyc(8);
    i_lvl = 2'b01; cyc(8);
    i_lvl = 2'b00; cyc(8);
    // R1, R7, R3, R8, R4: load while off, enable, frame, underrun, mark
    i_lvl = 2'b10; write(8'hA5); cyc(3);
    i_en = 1; cyc(60);
    i_clru = 1; cyc(1);
    // R3 back-to-back characters
    write(8'h3C); cyc(10); write(8'hC3); cyc(100);
    // R9 disable mid-character with character buffered, R11 pulse
    i_auto = 1;
    write(8'h5A); cyc(12); write(8'h81);
    i_en = 0; cyc(60);
    i_en = 1; cyc(80);
    // R10 disable while resting at mark
    i_en = 0; cyc(20);
    // R5 synchronous character then repeated sync pattern
    i_sync = 1; i_sc = 8'h96; write(8'h0F);
    i_en = 1; cyc(140);
    i_clru = 1; cyc(1);
    i_en = 0; cyc(40);
    i_sync = 0;
    rnd = 1;
    cyc(4000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule